// File: doc/BRIEF.md
# Four-Finger QPSK RAKE Despreader

This block is the front end of a direct-sequence spread-spectrum receiver. It takes a stream of complex 8-bit baseband chip samples and works through four fingers. Each finger is tied to one multipath copy of the signal, and each copy arrives a whole number of chips later than the reference. A finger multiplies its delayed samples by the complex conjugate of a locally generated QPSK spreading code and integrates over one symbol. It then rotates and scales the result by the conjugate of its own complex weight. The combiner adds the four weighted results into one maximal-ratio-combined symbol.

Incoming chips pass through a 64-entry delay line. Each finger picks its tap from a 6-bit delay value. Because the spreading code is generated for the oldest chip in the line, every finger's symbol boundary falls on the same clock. The combined output therefore appears once per symbol as a single-cycle strobe carrying signed 24-bit I and Q. The chip count per symbol is programmable from 4 to 256.

Top module: `rake_despreader`

## Requirements
- R1: While rst_ni is low, and after it until the first symbol, sym_valid_o is 0 and sym_i_o and sym_q_o are 0.
- R2: The delay line holds the 64 most recent chips. No symbol is produced before 64 chips have been accepted. The first chip accepted after reset is reference chip 0. A finger whose 6-bit field in delay_i holds d (0 to 63) pairs the code value of reference chip m with the sample accepted as chip m+d. Finger f uses bits [6f+5:6f], and each finger's delay is independent of the others.
- R3: The code for each reference chip comes from two 7-bit registers, seeded 7'h01 for I and 7'h4B for Q. Bit 0 of each register is the sign: 0 means +1 and 1 means -1. Both registers advance once per reference chip as s <= {s[5:0], s[6]^s[5]}. For sample r and code signs pi and pq, a finger accumulates (ri*pi + rq*pq) for I and (rq*pi - ri*pq) for Q. It sums over one symbol and starts from zero on every symbol.
- R4: A finger's despread value D is multiplied by the conjugate of its signed 8-bit weight W. Finger f's weight is at bits [8f+7:8f] of wgt_i_i and wgt_q_i. The result is I = Di*Wi + Dq*Wq and Q = Dq*Wi - Di*Wq.
- R5: The output symbol is the sum of the four fingers' weighted values.
- R6: The symbol length is sf_i clamped to the range 4 to 256. The value is taken while the line is filling and again at each symbol's last chip, so a change made mid-symbol first applies to the following symbol.
- R7: The combined I and Q saturate to the signed 24-bit range [-8388608, 8388607].
- R8: sym_valid_o is high for exactly one cycle per symbol. The output registers update on the third rising edge after the edge that accepts the symbol's last chip, and sym_i_o and sym_q_o hold their value between strobes.
- R9: Cycles with chip_valid_i low advance neither the delay line, nor the code, nor the symbol count. A stream with idle gaps gives the same symbols as the same chips sent back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_valid_i | input | 1 | Chip sample present this cycle |
| chip_i_i | input | 8 | Chip sample, in-phase, signed |
| chip_q_i | input | 8 | Chip sample, quadrature, signed |
| sf_i | input | 9 | Chips per symbol (clamped to 4..256) |
| delay_i | input | 24 | Four 6-bit finger delays in chips |
| wgt_i_i | input | 32 | Four signed 8-bit weight real parts |
| wgt_q_i | input | 32 | Four signed 8-bit weight imaginary parts |
| sym_valid_o | output | 1 | One-cycle strobe per combined symbol |
| sym_i_o | output | 24 | Combined symbol, in-phase, signed |
| sym_q_o | output | 24 | Combined symbol, quadrature, signed |

## Verification
The bench sets a different delay and weight on each finger. A swapped tap index, or a code advanced per sample instead of per reference chip, would then give mismatching symbols from the first strobe. Spreading factors below 4 and above 256 are sent, and one is changed mid-symbol. A design that skips the clamp, or takes the new length at once, would strobe at the wrong chip counts, and the scoreboard would see unexpected or missing symbols. Code-matched full-scale inputs with weights of +127 and -128 drive the sum past both 24-bit limits, where a wrapping design would flip sign. A stream with idle gaps checks that empty cycles do not step the line or the code.

// File: rtl/rake_pkg.sv
package rake_pkg;
  localparam int PN_W   = 7;
  localparam int SF_W   = 9;
  localparam int SF_MIN = 4;
  localparam int SF_MAX = 256;

  function automatic logic [PN_W-1:0] pn_next(logic [PN_W-1:0] s);
    return {s[PN_W-2:0], s[PN_W-1] ^ s[PN_W-2]};
  endfunction

  function automatic logic [SF_W-1:0] sf_clamp(logic [SF_W-1:0] v);
    if (v < SF_W'(SF_MIN)) return SF_W'(SF_MIN);
    if (v > SF_W'(SF_MAX)) return SF_W'(SF_MAX);
    return v;
  endfunction
endpackage

// File: rtl/rake_chip_line.sv
module rake_chip_line #(
  parameter int SAMP_W   = 8,
  parameter int DEPTH    = 64,
  parameter int NUM_TAPS = 4,
  parameter int DLY_W    = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         shift_i,
  input  logic signed [SAMP_W-1:0]     samp_i_i,
  input  logic signed [SAMP_W-1:0]     samp_q_i,
  input  logic [NUM_TAPS*DLY_W-1:0]    tap_sel_i,
  output logic [NUM_TAPS*SAMP_W-1:0]   tap_i_o,
  output logic [NUM_TAPS*SAMP_W-1:0]   tap_q_o
);
  logic signed [SAMP_W-1:0] mem_i [DEPTH];
  logic signed [SAMP_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) begin
        mem_i[k] <= '0;
        mem_q[k] <= '0;
      end
    end else if (shift_i) begin
      mem_i[0] <= samp_i_i;
      mem_q[0] <= samp_q_i;
      for (int k = 1; k < DEPTH; k++) begin
        mem_i[k] <= mem_i[k-1];
        mem_q[k] <= mem_q[k-1];
      end
    end
  end

  // oldest entry is the reference chip; delay d reaches d chips newer
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    logic [DLY_W-1:0] idx;
    assign idx = DLY_W'(DEPTH-1) - tap_sel_i[t*DLY_W +: DLY_W];
    assign tap_i_o[t*SAMP_W +: SAMP_W] = mem_i[idx];
    assign tap_q_o[t*SAMP_W +: SAMP_W] = mem_q[idx];
  end
endmodule

// File: rtl/rake_pn_gen.sv
module rake_pn_gen
  import rake_pkg::*;
#(
  parameter logic [PN_W-1:0] SEED_I = 7'h01,
  parameter logic [PN_W-1:0] SEED_Q = 7'h4B
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic pn_i_o,
  output logic pn_q_o
);
  logic [PN_W-1:0] st_i, st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_i <= SEED_I;
      st_q <= SEED_Q;
    end else if (step_i) begin
      st_i <= pn_next(st_i);
      st_q <= pn_next(st_q);
    end
  end

  assign pn_i_o = st_i[0];
  assign pn_q_o = st_q[0];
endmodule

// File: rtl/rake_finger.sv
module rake_finger #(
  parameter int SAMP_W = 8,
  parameter int WGT_W  = 8,
  parameter int ACC_W  = 18,
  parameter int PROD_W = ACC_W + WGT_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic                     dump_i,
  input  logic signed [SAMP_W-1:0] r_i_i,
  input  logic signed [SAMP_W-1:0] r_q_i,
  input  logic                     pn_i_i,
  input  logic                     pn_q_i,
  input  logic signed [WGT_W-1:0]  w_i_i,
  input  logic signed [WGT_W-1:0]  w_q_i,
  output logic                     y_valid_o,
  output logic signed [PROD_W-1:0] y_i_o,
  output logic signed [PROD_W-1:0] y_q_o
);
  localparam int EXT_W = SAMP_W + 1;
  localparam int TRM_W = SAMP_W + 2;

  logic signed [EXT_W-1:0] xi, xq, ip, qq, iq, qi;
  logic signed [TRM_W-1:0] term_i, term_q;
  logic signed [ACC_W-1:0] acc_i, acc_q, nxt_i, nxt_q, d_i, d_q;
  logic                    d_valid;

  // conjugate of a +-1 +-j chip: only negations
  always_comb begin
    xi = EXT_W'(r_i_i);
    xq = EXT_W'(r_q_i);
    ip = pn_i_i ? -xi : xi;
    qq = pn_q_i ? -xq : xq;
    iq = pn_i_i ? -xq : xq;
    qi = pn_q_i ? -xi : xi;
    term_i = TRM_W'(ip) + TRM_W'(qq);
    term_q = TRM_W'(iq) - TRM_W'(qi);
    nxt_i  = acc_i + ACC_W'(term_i);
    nxt_q  = acc_q + ACC_W'(term_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_i   <= '0;
      acc_q   <= '0;
      d_i     <= '0;
      d_q     <= '0;
      d_valid <= 1'b0;
    end else begin
      d_valid <= step_i & dump_i;
      if (step_i) begin
        if (dump_i) begin
          d_i   <= nxt_i;
          d_q   <= nxt_q;
          acc_i <= '0;
          acc_q <= '0;
        end else begin
          acc_i <= nxt_i;
          acc_q <= nxt_q;
        end
      end
    end
  end

  logic signed [PROD_W-1:0] di_x, dq_x, wi_x, wq_x;
  assign di_x = PROD_W'(d_i);
  assign dq_x = PROD_W'(d_q);
  assign wi_x = PROD_W'(w_i_i);
  assign wq_x = PROD_W'(w_q_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_i_o     <= '0;
      y_q_o     <= '0;
      y_valid_o <= 1'b0;
    end else begin
      y_valid_o <= d_valid;
      if (d_valid) begin
        y_i_o <= di_x * wi_x + dq_x * wq_x;
        y_q_o <= dq_x * wi_x - di_x * wq_x;
      end
    end
  end
endmodule

// File: rtl/rake_combiner.sv
module rake_combiner #(
  parameter int NUM_FINGERS = 4,
  parameter int PROD_W      = 27,
  parameter int OUT_W       = 24
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic [NUM_FINGERS*PROD_W-1:0] y_i_i,
  input  logic [NUM_FINGERS*PROD_W-1:0] y_q_i,
  output logic                          out_valid_o,
  output logic [OUT_W-1:0]              out_i_o,
  output logic [OUT_W-1:0]              out_q_o
);
  localparam int SUM_W = PROD_W + $clog2(NUM_FINGERS);
  localparam logic signed [SUM_W-1:0] MAX_V = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MIN_V = ~MAX_V;

  logic signed [SUM_W-1:0] sum_i, sum_q;

  always_comb begin
    sum_i = '0;
    sum_q = '0;
    for (int f = 0; f < NUM_FINGERS; f++) begin
      sum_i = sum_i + SUM_W'($signed(y_i_i[f*PROD_W +: PROD_W]));
      sum_q = sum_q + SUM_W'($signed(y_q_i[f*PROD_W +: PROD_W]));
    end
  end

  function automatic logic [OUT_W-1:0] sat(logic signed [SUM_W-1:0] v);
    if (v > MAX_V) return MAX_V[OUT_W-1:0];
    if (v < MIN_V) return MIN_V[OUT_W-1:0];
    return v[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_i_o     <= '0;
      out_q_o     <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_i_o <= sat(sum_i);
        out_q_o <= sat(sum_q);
      end
    end
  end
endmodule

// File: rtl/rake_despreader.sv
module rake_despreader
  import rake_pkg::*;
#(
  parameter int NUM_FINGERS = 4,
  parameter int SAMP_W      = 8,
  parameter int WGT_W       = 8,
  parameter int LINE_DEPTH  = 64,
  parameter int OUT_W       = 24,
  localparam int DLY_W      = $clog2(LINE_DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          chip_valid_i,
  input  logic signed [SAMP_W-1:0]      chip_i_i,
  input  logic signed [SAMP_W-1:0]      chip_q_i,
  input  logic [SF_W-1:0]               sf_i,
  input  logic [NUM_FINGERS*DLY_W-1:0]  delay_i,
  input  logic [NUM_FINGERS*WGT_W-1:0]  wgt_i_i,
  input  logic [NUM_FINGERS*WGT_W-1:0]  wgt_q_i,
  output logic                          sym_valid_o,
  output logic [OUT_W-1:0]              sym_i_o,
  output logic [OUT_W-1:0]              sym_q_o
);
  localparam int ACC_W  = SAMP_W + 2 + $clog2(SF_MAX);
  localparam int PROD_W = ACC_W + WGT_W + 1;
  localparam int FILL_W = DLY_W + 1;

  logic              valid_q, primed, step, dump;
  logic [FILL_W-1:0] fill_q;
  logic [SF_W-1:0]   sf_cur, sym_cnt;

  assign primed = (fill_q == FILL_W'(LINE_DEPTH));
  assign step   = valid_q & primed;
  assign dump   = step & (sym_cnt == sf_cur - SF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fill_q  <= '0;
      sf_cur  <= SF_W'(SF_MIN);
      sym_cnt <= '0;
    end else begin
      valid_q <= chip_valid_i;
      if (chip_valid_i && !primed) fill_q <= fill_q + FILL_W'(1);
      if (!primed || dump) sf_cur <= sf_clamp(sf_i);
      if (step) sym_cnt <= dump ? '0 : sym_cnt + SF_W'(1);
    end
  end

  logic [NUM_FINGERS*SAMP_W-1:0] tap_i, tap_q;

  rake_chip_line #(
    .SAMP_W(SAMP_W), .DEPTH(LINE_DEPTH), .NUM_TAPS(NUM_FINGERS), .DLY_W(DLY_W)
  ) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(chip_valid_i),
    .samp_i_i(chip_i_i), .samp_q_i(chip_q_i), .tap_sel_i(delay_i),
    .tap_i_o(tap_i), .tap_q_o(tap_q)
  );

  logic pn_i, pn_q;

  rake_pn_gen u_pn (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .pn_i_o(pn_i), .pn_q_o(pn_q)
  );

  logic [NUM_FINGERS-1:0]        y_valid;
  logic [NUM_FINGERS*PROD_W-1:0] y_i, y_q;

  for (genvar f = 0; f < NUM_FINGERS; f++) begin : g_finger
    rake_finger #(
      .SAMP_W(SAMP_W), .WGT_W(WGT_W), .ACC_W(ACC_W), .PROD_W(PROD_W)
    ) u_finger (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .dump_i(dump),
      .r_i_i(tap_i[f*SAMP_W +: SAMP_W]), .r_q_i(tap_q[f*SAMP_W +: SAMP_W]),
      .pn_i_i(pn_i), .pn_q_i(pn_q),
      .w_i_i(wgt_i_i[f*WGT_W +: WGT_W]), .w_q_i(wgt_q_i[f*WGT_W +: WGT_W]),
      .y_valid_o(y_valid[f]),
      .y_i_o(y_i[f*PROD_W +: PROD_W]), .y_q_o(y_q[f*PROD_W +: PROD_W])
    );
  end

  rake_combiner #(
    .NUM_FINGERS(NUM_FINGERS), .PROD_W(PROD_W), .OUT_W(OUT_W)
  ) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(&y_valid),
    .y_i_i(y_i), .y_q_i(y_q),
    .out_valid_o(sym_valid_o), .out_i_o(sym_i_o), .out_q_o(sym_q_o)
  );
endmodule

// File: rtl/rake_despreader_chk.sv
module rake_despreader_chk #(
  parameter int LINE_DEPTH = 64,
  parameter int OUT_W      = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chip_valid_i,
  input logic             sym_valid_o,
  input logic [OUT_W-1:0] sym_i_o,
  input logic [OUT_W-1:0] sym_q_o
);
  localparam int CNT_W = $clog2(LINE_DEPTH) + 1;
  logic [CNT_W-1:0] chips_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chips_seen <= '0;
    else if (chip_valid_i && chips_seen < CNT_W'(LINE_DEPTH)) chips_seen <= chips_seen + CNT_W'(1);
  end

  AST_VALID_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(sym_valid_o)); // R1

  AST_QUIET_UNTIL_FILLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chips_seen < CNT_W'(LINE_DEPTH)) |-> !sym_valid_o); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |=> !sym_valid_o); // R8

  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_o |-> ($stable(sym_i_o) && $stable(sym_q_o))); // R8

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> $past(chip_valid_i, 4)); // R8
endmodule

bind rake_despreader rake_despreader_chk #(.LINE_DEPTH(LINE_DEPTH), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chip_valid_i(chip_valid_i),
  .sym_valid_o(sym_valid_o), .sym_i_o(sym_i_o), .sym_q_o(sym_q_o)
);

// File: tb/tb_rake_despreader.sv
module tb_rake_despreader;
  localparam int NF = 4;
  localparam int MAXC = 4096;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic chip_valid = 1'b0;
  logic signed [7:0] chip_i = '0, chip_q = '0;
  logic [8:0] sf = 9'd8;
  logic [NF*6-1:0] delay = '0;
  logic [NF*8-1:0] wgt_i = '0, wgt_q = '0;
  logic sym_valid;
  logic [23:0] sym_i, sym_q;

  always #5 clk = ~clk;

  rake_despreader dut (
    .clk_i(clk), .rst_ni(rst_ni), .chip_valid_i(chip_valid),
    .chip_i_i(chip_i), .chip_q_i(chip_q), .sf_i(sf), .delay_i(delay),
    .wgt_i_i(wgt_i), .wgt_q_i(wgt_q),
    .sym_valid_o(sym_valid), .sym_i_o(sym_i), .sym_q_o(sym_q)
  );

  typedef struct { longint ei; longint eq; string req; } exp_t;
  exp_t sb[$];

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  int pni [MAXC];
  int pnq [MAXC];
  int rxi [MAXC];
  int rxq [MAXC];
  longint acc_i [NF];
  longint acc_q [NF];
  int dly [NF];
  int wi [NF];
  int wq [NF];
  int nchip, cnt, sf_cur, sf_val;
  string tag;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:16]) - 128;
  endfunction

  function automatic int clamp_sf(int v);
    if (v < 4) return 4;
    if (v > 256) return 256;
    return v;
  endfunction

  function automatic longint sat24(longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  task automatic apply_cfg();
    for (int f = 0; f < NF; f++) begin
      delay[f*6 +: 6] = 6'(dly[f]);
      wgt_i[f*8 +: 8] = 8'(wi[f]);
      wgt_q[f*8 +: 8] = 8'(wq[f]);
    end
    sf = 9'(sf_val);
  endtask

  // reference model of R2..R7
  task automatic model_chip();
    int j, m, si, sq, ri, rq;
    longint oi, oq;
    j = nchip - 1;
    if (j < 63) return;
    if (j == 63) sf_cur = clamp_sf(sf_val);
    m = j - 63;
    si = pni[m] ? -1 : 1;
    sq = pnq[m] ? -1 : 1;
    for (int f = 0; f < NF; f++) begin
      ri = rxi[m + dly[f]];
      rq = rxq[m + dly[f]];
      acc_i[f] += ri * si + rq * sq;
      acc_q[f] += rq * si - ri * sq;
    end
    cnt++;
    if (cnt == sf_cur) begin
      oi = 0; oq = 0;
      for (int f = 0; f < NF; f++) begin
        oi += acc_i[f] * wi[f] + acc_q[f] * wq[f];
        oq += acc_q[f] * wi[f] - acc_i[f] * wq[f];
        acc_i[f] = 0; acc_q[f] = 0;
      end
      sb.push_back('{sat24(oi), sat24(oq), tag});
      cnt = 0;
      sf_cur = clamp_sf(sf_val);
    end
  endtask

  task automatic send_chip(int vi, int vq);
    @(negedge clk);
    chip_valid = 1'b1;
    chip_i = 8'(vi);
    chip_q = 8'(vq);
    rxi[nchip] = vi;
    rxq[nchip] = vq;
    nchip++;
    model_chip();
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      chip_valid = 1'b0;
    end
  endtask

  task automatic send_rand(int n, int gap_every);
    for (int k = 0; k < n; k++) begin
      send_chip(rnd8(), rnd8());
      if (gap_every > 0 && (k % gap_every) == gap_every - 1) idle(2);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    chip_valid = 1'b0;
    nchip = 0; cnt = 0; sf_cur = 4;
    for (int f = 0; f < NF; f++) begin acc_i[f] = 0; acc_q[f] = 0; end
    sb.delete();
    apply_cfg();
    repeat (3) @(negedge clk);
    check(sym_valid == 1'b0, "R1", "valid in reset", longint'(sym_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(sym_valid == 1'b0 && sym_i == '0 && sym_q == '0, "R1", "outputs after reset",
          longint'(sym_i), 0);
  endtask

  task automatic finish_test(string req);
    idle(10);
    check(sb.size() == 0, req, "symbols missing", 0, longint'(sb.size()));
  endtask

  always @(negedge clk) begin
    if (rst_ni && sym_valid) begin
      if (sb.size() == 0) begin
        check(0, "R8", "unexpected symbol", longint'($signed(sym_i)), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(longint'($signed(sym_i)) == e.ei, e.req, "sym I", longint'($signed(sym_i)), e.ei);
        check(longint'($signed(sym_q)) == e.eq, e.req, "sym Q", longint'($signed(sym_q)), e.eq);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] s_i, s_q;
    s_i = 7'h01; s_q = 7'h4B;
    for (int k = 0; k < MAXC; k++) begin
      pni[k] = int'(s_i[0]);
      pnq[k] = int'(s_q[0]);
      s_i = {s_i[5:0], s_i[6] ^ s_i[5]};
      s_q = {s_q[5:0], s_q[6] ^ s_q[5]};
    end

    // R3, R2: single finger, zero delay
    tag = "R3";
    dly = '{0, 0, 0, 0}; wi = '{1, 0, 0, 0}; wq = '{0, 0, 0, 0}; sf_val = 8;
    do_reset();
    send_rand(63 + 8 * 8, 0);
    finish_test("R3");

    // R2, R4: distinct delays and complex weights
    tag = "R4";
    dly = '{0, 5, 17, 63}; wi = '{37, -90, 12, 127}; wq = '{-64, 25, -128, 3}; sf_val = 16;
    do_reset();
    send_rand(63 + 16 * 6, 0);
    finish_test("R4");

    // R5, R2: all fingers active, one at the far tap, weights real only
    tag = "R5";
    dly = '{63, 1, 2, 40}; wi = '{10, 20, -30, 40}; wq = '{0, 0, 0, 0}; sf_val = 12;
    do_reset();
    send_rand(63 + 12 * 5, 0);
    finish_test("R5");

    // R1: reset clears outputs after symbols have been produced
    tag = "R1";
    do_reset();

    // R6: clamp below and above range
    tag = "R6";
    dly = '{3, 0, 9, 1}; wi = '{5, 6, 7, 8}; wq = '{-1, 2, -3, 4}; sf_val = 1;
    do_reset();
    send_rand(63 + 4 * 5, 0);
    finish_test("R6");
    sf_val = 400;
    do_reset();
    send_rand(63 + 256 * 2, 0);
    finish_test("R6");

    // R6: change mid-symbol applies to next symbol
    sf_val = 8;
    do_reset();
    send_rand(63 + 8 + 3, 0);
    sf_val = 16;
    apply_cfg();
    send_rand(5 + 16 * 3, 0);
    finish_test("R6");

    // R9: idle gaps in the chip stream
    tag = "R9";
    dly = '{2, 30, 7, 55}; wi = '{-20, 33, 100, -7}; wq = '{45, -11, 0, 90}; sf_val = 8;
    do_reset();
    send_rand(63 + 8 * 6, 3);
    finish_test("R9");

    // R7: positive and negative saturation with code-matched input
    tag = "R7";
    dly = '{0, 0, 0, 0}; wi = '{127, 127, 127, 127}; wq = '{0, 0, 0, 0}; sf_val = 256;
    do_reset();
    for (int k = 0; k < 63 + 256; k++)
      send_chip(pni[k] ? -127 : 127, pnq[k] ? -127 : 127);
    finish_test("R7");
    wi = '{-128, -128, -128, -128};
    do_reset();
    for (int k = 0; k < 63 + 256; k++)
      send_chip(pni[k] ? -127 : 127, pnq[k] ? -127 : 127);
    finish_test("R7");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule